// File: doc/BRIEF.md
# I2C Serial Memory Read Target

This block is the target side of an I2C link that serves reads from a byte-wide memory. It oversamples SCL and SDA with the system clock, finds Start, repeated Start and Stop conditions, and decodes a control byte made of a fixed device pattern, three strap-selected chip-select bits and a read/write flag. A persistent address pointer selects the memory location. A write-type transaction carries a two-byte word address that loads the pointer. A read-type transaction shifts out data bytes for as long as the controller keeps acknowledging them.

The memory sits outside the block behind a simple read port. The block presents the pointer on `mem_addr`, and the memory returns the byte on `mem_rdata` combinationally or within one clock. All three read forms come from the same logic: a current-address read, a random read (address write, repeated Start, then read) and a sequential read. The pointer advances by one after every byte shifted out, whatever the read form. `sda_oe` is an open-drain enable: 1 pulls the bus low and 0 releases it.

Top module: `i2c_rd_target`

## Requirements
- R1: A control byte is accepted only when its upper four bits are 1010 and bits 3:1 equal `sel`. Bit 0 is the read/write flag, with 1 meaning read. An accepted control byte is acknowledged by holding SDA low during the ninth SCL pulse.
- R2: A control byte that fails the pattern or the chip-select match is not acknowledged. The block then leaves SDA released and ignores every byte until the next Start or Stop, and the pointer does not change.
- R3: After a write-type control byte, two address bytes follow, high byte first, and each is acknowledged. When the second byte is complete, the pointer loads the low ADDR_W bits of the 16-bit word. Further bytes in the same write are not acknowledged.
- R4: A random read returns the byte at the loaded address. The address phase ends with a repeated Start, and the pointer keeps the loaded value.
- R5: Data bytes are shifted out MSB first. SDA driven by the block changes only while SCL is low.
- R6: A read-type control byte with no address phase returns the byte at the current pointer, which is one past the last byte read.
- R7: When the controller acknowledges a data byte, the block sends the byte at the next address in the same transaction, with no limit on the count.
- R8: The pointer increments by one after each data byte is sent, and wraps from all ones to zero.
- R9: After a not-acknowledged byte and a Stop, SDA is released and the pointer points one past the last byte sent.
- R10: Out of reset, SDA is released and the pointer is zero. A Stop returns the block to idle, and a Start at any point begins a fresh control-byte decode.
- R11: A write that ends, by Stop or Start, before the second address byte is complete leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sel | input | 3 | Chip-select strap compared with control-byte bits 3:1 |
| mem_addr | output | ADDR_W | Address pointer presented to the memory |
| mem_rdata | input | 8 | Byte read from the memory at mem_addr |

## Verification
The bench builds the block with ADDR_W set to 8. This makes the pointer wrap from FF to 00 reachable within a few bytes of a sequential read. It also means a word address with a non-zero high byte shows the truncation to the low bits. The chip-select strap is tied to 101, so a control byte with a different select value tests the mismatch path. The bench memory model is a bijective function of the address, so any read from the wrong location returns a byte that differs from the expected one.

// File: rtl/i2c_rd_target.sv
module i2c_rd_target #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        sel,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata
);
  typedef enum logic [3:0] {
    S_IDLE, S_CTRL, S_ACKC, S_AHI, S_ACKH, S_ALO, S_ACKL, S_TX, S_RACK, S_IGN
  } st_t;

  st_t               st;
  logic [1:0]        scl_sy, sda_sy;
  logic              scl_q, sda_q;
  logic [3:0]        bits;
  logic [7:0]        sh, tx, hi;
  logic              rw, nack;
  logic [ADDR_W-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end

  wire scl_s     = scl_sy[1];
  wire sda_s     = sda_sy[1];
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire hit       = (sh[7:4] == 4'b1010) && (sh[3:1] == sel);
  wire [15:0] waddr = {hi, sh};
  wire rx_state  = (st == S_CTRL) || (st == S_AHI) || (st == S_ALO);
  wire acking    = (st == S_ACKC) || (st == S_ACKH) || (st == S_ACKL);
  wire in_tx     = (st == S_TX);
  wire ign       = (st == S_IGN);

  assign sda_oe   = acking | (in_tx & ~tx[7]);
  assign mem_addr = ptr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; bits <= '0; sh <= '0; tx <= 8'hFF; hi <= '0;
      rw <= 1'b0; nack <= 1'b1; ptr <= '0;
    end else if (stop_det) begin
      st <= S_IDLE;
    end else if (start_det) begin
      st <= S_CTRL; bits <= '0;
    end else if (rx_state) begin
      if (scl_rise && bits != 4'd8) begin
        sh   <= {sh[6:0], sda_s};
        bits <= bits + 4'd1;
      end else if (scl_fall && bits == 4'd8) begin
        case (st)
          S_CTRL: if (hit) begin st <= S_ACKC; rw <= sh[0]; end
                  else st <= S_IGN;
          S_AHI:  begin hi <= sh; st <= S_ACKH; end
          default: begin ptr <= waddr[ADDR_W-1:0]; st <= S_ACKL; end
        endcase
      end
    end else if (scl_fall) begin
      case (st)
        S_ACKC: begin
          bits <= '0;
          if (rw) begin tx <= mem_rdata; st <= S_TX; end
          else st <= S_AHI;
        end
        S_ACKH: begin bits <= '0; st <= S_ALO; end
        S_ACKL: st <= S_IGN;
        S_TX:
          if (bits == 4'd7) begin st <= S_RACK; ptr <= ptr + 1'b1; end
          else begin tx <= {tx[6:0], 1'b0}; bits <= bits + 4'd1; end
        S_RACK:
          if (!nack) begin tx <= mem_rdata; bits <= '0; st <= S_TX; end
          else st <= S_IGN;
        default: ;
      endcase
    end else if (scl_rise && st == S_RACK) begin
      nack <= sda_s;
    end
endmodule

module i2c_rd_target_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              in_tx,
  input logic              ign,
  input logic              stop_det
);
  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i); // R5
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_tx) && mem_addr != $past(mem_addr)) |-> mem_addr == $past(mem_addr) + 1'b1); // R8
  AST_PTR_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr != $past(mem_addr)) |-> !scl_i); // R3
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe); // R9
  AST_IGN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ign && $past(ign)) |-> $stable(mem_addr)); // R2
  AST_IGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ign |-> !sda_oe); // R2
endmodule

bind i2c_rd_target i2c_rd_target_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .mem_addr(mem_addr),
  .in_tx(in_tx), .ign(ign), .stop_det(stop_det)
);

// File: tb/i2c_rd_target_test.sv
module i2c_rd_target_test;
  localparam int AW = 8;
  localparam int Q  = 8;
  localparam logic [2:0] SEL = 3'b101;
  localparam logic [7:0] CW = {4'b1010, SEL, 1'b0};
  localparam logic [7:0] CR = {4'b1010, SEL, 1'b1};
  localparam int NV = 9;
  // kind[3:0] (0 random, 1 current), word address[15:0], byte count[3:0]
  localparam logic [23:0] VEC [NV] = '{
    {4'd0, 16'h0010, 4'd1}, {4'd1, 16'h0000, 4'd1}, {4'd1, 16'h0000, 4'd3},
    {4'd0, 16'h12F0, 4'd2}, {4'd0, 16'h00FD, 4'd5}, {4'd1, 16'h0000, 4'd2},
    {4'd0, 16'h0080, 4'd4}, {4'd0, 16'h00FF, 4'd1}, {4'd1, 16'h0000, 4'd1}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_rdata;
  wire sda_bus = sda_m & ~sda_oe;

  function automatic logic [7:0] mfun(input logic [AW-1:0] a);
    return (8'(a) * 8'd37) ^ 8'h5A;
  endfunction
  assign mem_rdata = mfun(mem_addr);

  i2c_rd_target #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .sel(SEL), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  int total = 0, bad = 0, viol = 0;
  logic prev_oe = 1'b0;
  logic [AW-1:0] mp;
  logic ack;
  logic [7:0] d;

  always @(posedge clk) begin
    #1;
    if (rst_n && sda_oe !== prev_oe && scl) viol++;
    prev_oe = sda_oe;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tk(input int n); repeat (n) @(negedge clk); endtask

  task automatic sbit(input logic b);
    sda_m = b; tk(Q); scl = 1'b1; tk(2 * Q); scl = 1'b0; tk(Q);
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; tk(Q); scl = 1'b1; tk(Q); b = sda_bus; tk(Q); scl = 1'b0; tk(Q);
  endtask

  task automatic bstart;
    sda_m = 1'b1; tk(Q); scl = 1'b1; tk(Q); sda_m = 1'b0; tk(Q); scl = 1'b0; tk(Q);
  endtask

  task automatic bstop;
    sda_m = 1'b0; tk(Q); scl = 1'b1; tk(Q); sda_m = 1'b1; tk(Q);
  endtask

  task automatic wbyte(input logic [7:0] v, output logic a);
    logic b;
    for (int i = 7; i >= 0; i--) sbit(v[i]);
    rbit(b);
    a = ~b;
  endtask

  task automatic rbyte(output logic [7:0] v, input logic mack);
    logic b;
    v = '0;
    for (int i = 0; i < 8; i++) begin rbit(b); v = {v[6:0], b}; end
    sbit(~mack);
  endtask

  task automatic set_addr(input logic [15:0] a);
    bstart;
    wbyte(CW, ack);     chk("R1 write control ack", ack, 1);
    wbyte(a[15:8], ack); chk("R3 high address ack", ack, 1);
    wbyte(a[7:0], ack);  chk("R3 low address ack", ack, 1);
    mp = a[AW-1:0];
  endtask

  task automatic do_read(input int n, input bit rnd);
    bstart;
    wbyte(CR, ack); chk("R1 read control ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      rbyte(d, k != n - 1);
      chk(k != 0 ? "R7 R5 sequential byte" : (rnd ? "R4 R5 random byte" : "R6 R5 current byte"),
          d, mfun(mp));
      mp = mp + 1'b1;
    end
    bstop;
    tk(4);
    chk("R8 pointer after read", mem_addr, mp);
    chk("R9 sda released after stop", sda_oe, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R10 watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tk(5);
    chk("R10 reset sda_oe", sda_oe, 0);
    chk("R10 reset pointer", mem_addr, 0);
    rst_n = 1'b1;
    tk(5);
    mp = '0;

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][23:20] == 4'd0) begin
        set_addr(VEC[v][19:4]);
        do_read(int'(VEC[v][3:0]), 1'b1);
      end else begin
        do_read(int'(VEC[v][3:0]), 1'b0);
      end
    end

    // R2: chip-select mismatch
    bstart;
    wbyte({4'b1010, 3'b011, 1'b1}, ack); chk("R2 select mismatch no ack", ack, 0);
    wbyte(8'h00, ack);                   chk("R2 later byte ignored", ack, 0);
    bstop; tk(4);
    chk("R2 pointer unchanged on mismatch", mem_addr, mp);

    // R2: pattern mismatch
    bstart;
    wbyte({4'b1011, SEL, 1'b0}, ack); chk("R2 pattern mismatch no ack", ack, 0);
    bstop; tk(4);
    chk("R2 pointer unchanged on bad pattern", mem_addr, mp);

    // R11: stop after high address byte only
    bstart;
    wbyte(CW, ack);    chk("R1 control ack", ack, 1);
    wbyte(8'h44, ack); chk("R3 high byte ack", ack, 1);
    bstop; tk(4);
    chk("R11 pointer kept after partial address", mem_addr, mp);

    // R11 R10: repeated start after high byte, then current read
    bstart;
    wbyte(CW, ack);
    wbyte(8'h66, ack);
    do_read(2, 1'b0);

    // R3: full address then data byte then stop, pointer loaded
    set_addr(16'hAB33);
    wbyte(8'h55, ack); chk("R3 data byte after address not acked", ack, 0);
    bstop; tk(4);
    chk("R3 pointer loaded from low bits", mem_addr, 8'h33);
    do_read(1, 1'b0);

    chk("R5 sda changes only with scl low", viol, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule